// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block governs the sleep states of a small microcontroller core. Software asks for a light sleep, in which only the instruction clock stops, or for a deep sleep, in which the oscillator itself is switched off. The block drives the clock enables for the CPU and for the peripherals, the oscillator run control, a one-cycle strobe that reinitialises the special function registers, and an inhibit line that blocks internal RAM access.

The two sleep states have different ways out. A light sleep ends on any enabled interrupt, which returns the core to normal execution with no register reset. It can also end on the external reset pin. In that case the CPU clock comes back for a fixed resume window of two machine cycles before the reset sequence takes over. During that window RAM access is blocked, but port writes still go through. A deep sleep ignores interrupts completely and ends only on the external reset. The reset sequence then keeps the core held until the reset pin is released and the oscillator reports that it is stable. RAM content is never cleared by the block. Only the register strobe is issued.

Top module: `lpm_seq`

## Requirements
- R1: In the run state, `cpu_clk_en`, `per_clk_en` and `osc_run` are 1, and `ram_inhibit` and `sfr_rst` are 0.
- R2: Light sleep is entered only from run, on the clock edge that samples `idle_req`=1 and `pd_req`=0. In light sleep `cpu_clk_en`=0 while `per_clk_en`=1 and `osc_run`=1.
- R3: `pd_req`=1 sampled in run enters deep sleep, where `cpu_clk_en`, `per_clk_en` and `osc_run` are all 0. When `idle_req` and `pd_req` are sampled together, deep sleep wins.
- R4: In light sleep, any set bit of `irq_req` (with `hw_reset`=0) returns to run on the next edge. No `sfr_rst` is issued and `ram_inhibit` stays 0.
- R5: In deep sleep, `irq_req` has no effect: the outputs stay all 0 for as long as `hw_reset` is 0.
- R6: `hw_reset`=1 sampled in light sleep starts a resume window of `MC_CLKS*WIN_MC` cycles (24 by default). In that window `cpu_clk_en`=1, `per_clk_en`=1 and `ram_inhibit`=1. The reset sequence follows, whatever `hw_reset` does during the window.
- R7: In the reset sequence `cpu_clk_en`=0, `per_clk_en`=0, `osc_run`=1 and `ram_inhibit`=1. The sequence holds as long as `hw_reset`=1 or `osc_stable`=0.
- R8: `sfr_rst` is high for exactly one cycle, the first run cycle after the reset sequence releases. It is high at no other time.
- R9: Deep sleep is left only through `hw_reset`=1, which enters the reset sequence with `osc_run`=1. Release waits for `osc_stable`=1.
- R10: `hw_reset`=1 sampled in run enters the reset sequence on the next edge.
- R11: While `rst_n`=0 the block sits in the reset sequence with the outputs of R7. After `rst_n` rises it releases as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| idle_req | input | 1 | Software request for light sleep |
| pd_req | input | 1 | Software request for deep sleep |
| irq_req | input | N_IRQ | Enabled interrupt requests, one bit per source |
| hw_reset | input | 1 | External reset pin, active high |
| osc_stable | input | 1 | Oscillator has restarted and is stable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run enable |
| sfr_rst | output | 1 | One-cycle register reinitialise strobe |
| ram_inhibit | output | 1 | Blocks internal RAM access |

## Verification
Each way into and out of sleep is driven in turn:
- A lone `idle_req`, followed by a single interrupt bit, separates the wake-by-interrupt path from any register reset.
- Simultaneous `idle_req` and `pd_req` show the deep-sleep priority.
- Every interrupt bit raised during deep sleep shows that those requests are ignored.
- Reset during light sleep is applied two ways. A one-cycle pulse shows that the resume window has a fixed length. A pin held far past the window shows that the reset sequence waits for the pin to drop.
- Deep-sleep exit with `osc_stable` kept low after the pin falls shows that release waits for the oscillator.

A behavioural model follows all of this cycle by cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      LPM_RUN    = 3'd0,
      LPM_IDLE   = 3'd1,
      LPM_PDOWN  = 3'd2,
      LPM_RESUME = 3'd3,
      LPM_RSTSEQ = 3'd4
   } lpm_state_e;

   typedef struct packed {
      logic cpu;
      logic per;
      logic osc;
      logic ram_blk;
   } lpm_gate_t;

   function automatic lpm_gate_t lpm_gate_of(lpm_state_e s);
      lpm_gate_t g;
      case (s)
         LPM_RUN:    g = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, ram_blk: 1'b0};
         LPM_IDLE:   g = '{cpu: 1'b0, per: 1'b1, osc: 1'b1, ram_blk: 1'b0};
         LPM_PDOWN:  g = '{cpu: 1'b0, per: 1'b0, osc: 1'b0, ram_blk: 1'b0};
         LPM_RESUME: g = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, ram_blk: 1'b1};
         default:    g = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, ram_blk: 1'b1};
      endcase
      return g;
   endfunction

endpackage

// File: rtl/lpm_win_cnt.sv
module lpm_win_cnt #(
   parameter int unsigned WIN_CLKS = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_win,
   output logic win_done
);
   localparam int unsigned CNT_W = (WIN_CLKS > 1) ? $clog2(WIN_CLKS) : 1;

   generate
      if (WIN_CLKS <= 1) begin : g_short
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ in_win;
         assign win_done  = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt_q <= '0;
            else if (!in_win) cnt_q <= '0;
            else if (!win_done) cnt_q <= cnt_q + 1'b1;
         end
         assign win_done = (cnt_q == CNT_W'(WIN_CLKS - 1));
      end
   endgenerate
endmodule

// File: rtl/lpm_next.sv
module lpm_next
   import lpm_pkg::*;
#(
   parameter bit HAS_WIN = 1'b1
) (
   input  lpm_state_e cur,
   input  logic       idle_req,
   input  logic       pd_req,
   input  logic       irq_any,
   input  logic       hw_reset,
   input  logic       osc_stable,
   input  logic       win_done,
   output lpm_state_e nxt,
   output logic       release_now
);
   always_comb begin
      nxt         = cur;
      release_now = 1'b0;
      case (cur)
         LPM_RUN: begin
            if (hw_reset)      nxt = LPM_RSTSEQ;
            else if (pd_req)   nxt = LPM_PDOWN;
            else if (idle_req) nxt = LPM_IDLE;
         end
         LPM_IDLE: begin
            if (hw_reset)     nxt = HAS_WIN ? LPM_RESUME : LPM_RSTSEQ;
            else if (irq_any) nxt = LPM_RUN;
         end
         LPM_PDOWN: begin
            if (hw_reset) nxt = LPM_RSTSEQ;
         end
         LPM_RESUME: begin
            if (win_done) nxt = LPM_RSTSEQ;
         end
         LPM_RSTSEQ: begin
            if (!hw_reset && osc_stable) begin
               nxt         = LPM_RUN;
               release_now = 1'b1;
            end
         end
         default: nxt = LPM_RSTSEQ;
      endcase
   end
endmodule

// File: rtl/lpm_gate_dec.sv
module lpm_gate_dec
   import lpm_pkg::*;
(
   input  lpm_state_e st,
   output logic       cpu_en,
   output logic       per_en,
   output logic       osc_en,
   output logic       ram_blk
);
   lpm_gate_t g;
   always_comb g = lpm_gate_of(st);
   assign cpu_en  = g.cpu;
   assign per_en  = g.per;
   assign osc_en  = g.osc;
   assign ram_blk = g.ram_blk;
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
   import lpm_pkg::*;
#(
   parameter int unsigned N_IRQ   = 5,
   parameter int unsigned MC_CLKS = 12,
   parameter int unsigned WIN_MC  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idle_req,
   input  logic             pd_req,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic             hw_reset,
   input  logic             osc_stable,
   output logic             cpu_clk_en,
   output logic             per_clk_en,
   output logic             osc_run,
   output logic             sfr_rst,
   output logic             ram_inhibit
);
   localparam int unsigned WIN_CLKS = MC_CLKS * WIN_MC;
   localparam bit          HAS_WIN  = (WIN_CLKS != 0);

   generate
      if (N_IRQ < 1) begin : g_bad_irq
         $error("lpm_seq: N_IRQ must be at least 1");
      end
      if (MC_CLKS < 1) begin : g_bad_mc
         $error("lpm_seq: MC_CLKS must be at least 1");
      end
   endgenerate

   lpm_state_e state_q, state_d;
   logic       release_now, win_done, sfr_q;
   logic       irq_any;

   assign irq_any = |irq_req;

   lpm_win_cnt #(.WIN_CLKS(WIN_CLKS)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_win   (state_q == LPM_RESUME),
      .win_done (win_done)
   );

   lpm_next #(.HAS_WIN(HAS_WIN)) u_next (
      .cur         (state_q),
      .idle_req    (idle_req),
      .pd_req      (pd_req),
      .irq_any     (irq_any),
      .hw_reset    (hw_reset),
      .osc_stable  (osc_stable),
      .win_done    (win_done),
      .nxt         (state_d),
      .release_now (release_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LPM_RSTSEQ;
         sfr_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         sfr_q   <= release_now;
      end
   end

   lpm_gate_dec u_gate (
      .st      (state_q),
      .cpu_en  (cpu_clk_en),
      .per_en  (per_clk_en),
      .osc_en  (osc_run),
      .ram_blk (ram_inhibit)
   );

   assign sfr_rst = sfr_q;
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk #(
   parameter int unsigned N_IRQ   = 5,
   parameter int unsigned MC_CLKS = 12,
   parameter int unsigned WIN_MC  = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             idle_req,
   input logic             pd_req,
   input logic [N_IRQ-1:0] irq_req,
   input logic             hw_reset,
   input logic             osc_stable,
   input logic             cpu_clk_en,
   input logic             per_clk_en,
   input logic             osc_run,
   input logic             sfr_rst,
   input logic             ram_inhibit
);
   localparam int unsigned WIN_CLKS = MC_CLKS * WIN_MC;

   logic [15:0] win_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         win_run <= '0;
      else if (cpu_clk_en && ram_inhibit) win_run <= win_run + 16'd1;
      else                                win_run <= '0;
   end

   AST_RUN_ALL_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_clk_en && !ram_inhibit) |-> (per_clk_en && osc_run)); // R1
   AST_IDLE_BY_SW: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_clk_en && per_clk_en && !ram_inhibit && $past(cpu_clk_en && !ram_inhibit))
      |-> ($past(idle_req) && !$past(pd_req))); // R2
   AST_PD_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_run |-> (!cpu_clk_en && !per_clk_en)); // R3
   AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_clk_en && per_clk_en && !ram_inhibit && (|irq_req) && !hw_reset)
      |=> (cpu_clk_en && !ram_inhibit && !sfr_rst)); // R4
   AST_PD_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_run && !hw_reset) |=> !osc_run); // R5
   AST_WIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      win_run <= 16'(WIN_CLKS)); // R6
   AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!per_clk_en && osc_run && (hw_reset || !osc_stable)) |=> !cpu_clk_en); // R7
   AST_SFR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      sfr_rst |=> !sfr_rst); // R8
   AST_SFR_FROM_RST: assert property (@(posedge clk) disable iff (!rst_n)
      sfr_rst |-> $past(!per_clk_en && osc_run && osc_stable && !hw_reset)); // R8
   AST_PD_EXIT_RST: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_run && hw_reset) |=> (osc_run && ram_inhibit && !cpu_clk_en)); // R9
   AST_RUN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_clk_en && !ram_inhibit && hw_reset) |=> (!cpu_clk_en && ram_inhibit)); // R10
endmodule

bind lpm_seq lpm_seq_chk #(.N_IRQ(N_IRQ), .MC_CLKS(MC_CLKS), .WIN_MC(WIN_MC)) u_chk (
   .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .pd_req(pd_req),
   .irq_req(irq_req), .hw_reset(hw_reset), .osc_stable(osc_stable),
   .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_run(osc_run),
   .sfr_rst(sfr_rst), .ram_inhibit(ram_inhibit)
);

// File: tb/lpm_seq_test.sv
module lpm_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int N_IRQ      = 5;
   localparam int WIN        = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic idle_req = 1'b0, pd_req = 1'b0, hw_reset = 1'b0, osc_stable = 1'b1;
   logic [N_IRQ-1:0] irq_req = '0;
   logic cpu_clk_en, per_clk_en, osc_run, sfr_rst, ram_inhibit;

   always #(CLK_PERIOD/2) clk = ~clk;

   lpm_seq uut (
      .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .pd_req(pd_req),
      .irq_req(irq_req), .hw_reset(hw_reset), .osc_stable(osc_stable),
      .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_run(osc_run),
      .sfr_rst(sfr_rst), .ram_inhibit(ram_inhibit)
   );

   int tests = 0, fails = 0, sfr_seen = 0;
   string cur_req = "R11";

   // reference model: 0 run, 1 light sleep, 2 deep sleep, 3 resume window, 4 reset sequence
   int m_st = 4, m_cnt = 0;
   bit m_sfr = 0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st <= 4; m_cnt <= 0; m_sfr <= 0;
      end else begin
         m_sfr <= 0;
         case (m_st)
            0: if (hw_reset) m_st <= 4; else if (pd_req) m_st <= 2; else if (idle_req) m_st <= 1;
            1: if (hw_reset) begin m_st <= 3; m_cnt <= 0; end else if (irq_req != 0) m_st <= 0;
            2: if (hw_reset) m_st <= 4;
            3: if (m_cnt == WIN - 1) m_st <= 4; else m_cnt <= m_cnt + 1;
            default: if (!hw_reset && osc_stable) begin m_st <= 0; m_sfr <= 1; end
         endcase
      end
   end

   function automatic logic [4:0] exp_out(int st, bit sfr);
      logic [4:0] v;
      case (st)
         0: v = 5'b11100;
         1: v = 5'b01100;
         2: v = 5'b00000;
         3: v = 5'b11101;
         default: v = 5'b00101;
      endcase
      v[1] = sfr;
      return v;
   endfunction

   wire [4:0] act = {cpu_clk_en, per_clk_en, osc_run, sfr_rst, ram_inhibit};

   always @(negedge clk) begin
      if (rst_n) begin
         tests++;
         if (sfr_rst) sfr_seen++;
         if (act !== exp_out(m_st, m_sfr)) begin
            fails++;
            $display("FAIL %s: cycle compare actual %b expected %b", cur_req, act, exp_out(m_st, m_sfr));
         end
      end
   end

   task automatic chk(input string req, input logic [4:0] a, input logic [4:0] e);
      tests++;
      if (a !== e) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, a, e);
      end
   endtask

   task automatic cyc(input int n = 1);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not end, actual running expected done");
      summary();
   end

   initial begin
      int wlen;
      cyc(3);
      chk("R11", act, 5'b00101);
      rst_n = 1'b1;
      cur_req = "R8";
      cyc(1);
      chk("R8", act, 5'b11110);
      cyc(1);
      chk("R1", act, 5'b11100);
      cur_req = "R1";
      cyc(3);
      chk("R1", act, 5'b11100);

      cur_req = "R2";
      idle_req = 1; cyc(1); idle_req = 0;
      chk("R2", act, 5'b01100);
      cyc(4);
      chk("R2", act, 5'b01100);

      cur_req = "R4";
      irq_req = 5'b00100; cyc(1); irq_req = '0;
      chk("R4", act, 5'b11100);
      cyc(2);

      cur_req = "R3";
      idle_req = 1; pd_req = 1; cyc(1); idle_req = 0; pd_req = 0;
      chk("R3", act, 5'b00000);

      cur_req = "R5";
      irq_req = '1; cyc(6);
      chk("R5", act, 5'b00000);
      irq_req = 5'b10000; cyc(2); irq_req = '0;
      chk("R5", act, 5'b00000);

      cur_req = "R9";
      osc_stable = 0; hw_reset = 1; cyc(2);
      chk("R9", act, 5'b00101);
      hw_reset = 0; cyc(5);
      chk("R7", act, 5'b00101);
      osc_stable = 1; cyc(1);
      chk("R9", act, 5'b11110);
      cyc(2);

      cur_req = "R6";
      idle_req = 1; cyc(1); idle_req = 0;
      hw_reset = 1; cyc(1); hw_reset = 0;
      wlen = 0;
      for (int i = 0; i < 100; i++) begin
         if (!(cpu_clk_en && ram_inhibit)) break;
         wlen++;
         cyc(1);
      end
      tests++;
      if (wlen != WIN) begin
         fails++;
         $display("FAIL R6: window length actual %0d expected %0d", wlen, WIN);
      end
      chk("R6", act, 5'b00101);
      cyc(1);
      chk("R8", act, 5'b11110);
      cyc(2);

      cur_req = "R7";
      idle_req = 1; cyc(1); idle_req = 0;
      hw_reset = 1; cyc(WIN + 30);
      chk("R7", act, 5'b00101);
      hw_reset = 0; cyc(1);
      chk("R7", act, 5'b11110);
      cyc(2);

      cur_req = "R10";
      hw_reset = 1; cyc(1); hw_reset = 0;
      chk("R10", act, 5'b00101);
      cyc(3);

      tests++;
      if (sfr_seen != 5) begin
         fails++;
         $display("FAIL R8: strobe count actual %0d expected %0d", sfr_seen, 5);
      end
      summary();
   end
endmodule